// File: doc/BRIEF.md
# DDR2 Bank State and Data-Phase Tracker

This block sits on the controller side of a single x8 DDR2 SDRAM with eight banks. Each cycle it may receive one decoded command: activate, read, write, single-bank precharge, all-bank precharge or refresh. The command carries a bank index, a row address, an auto-precharge request and a burst-type bit. The block keeps an open/closed record and the open row for every bank. It judges each command legal or illegal in the same cycle, and only legal commands change its state.

For every accepted read or write it schedules a data window. The read window starts at the read latency, which is additive latency plus CAS latency. The write window starts one cycle earlier. Each window lasts half the burst length in clock cycles. When auto-precharge is requested, the bank closes by itself in the cycle after its data window ends. A saturating cycle counter raises an overdue flag when no refresh has been accepted for longer than a programmable interval. The default interval is about 7.8 us at 533 MHz, which gives 8192 refreshes in 64 ms.

Top module: `ddr2_bank_tracker`

## Requirements
- R1: Opcode 1 (activate) to a closed bank is legal, opens the bank and records `cmd_row`. An activate to an open bank is illegal. `sel_row` shows the open row of the bank selected by `cmd_bank`, or zero when that bank is closed.
- R2: Opcode 2 (read) and opcode 3 (write) are legal only when the bank is open and has no auto-precharge pending. An illegal command changes no bank state and schedules no data window.
- R3: Opcode 4 (precharge) is always legal. It closes the addressed bank, cancels any pending auto-precharge, and does nothing to a bank that is already closed. Opcode 5 (precharge-all) is always legal and closes all eight banks in one cycle.
- R4: Opcode 6 (refresh) is legal only when all eight bits of `bank_open` are zero.
- R5: After a read accepted in cycle t, `rd_strobe` is high from cycle t+RL for BL/2 cycles. RL = AL + CL, where AL is `cfg_al` capped at 6 and CL is `cfg_cl` held within 2..7.
- R6: After a write accepted in cycle t, `wr_strobe` is high from cycle t+RL-1 for BL/2 cycles.
- R7: When `cfg_bl8` is 1 the burst length is 8 (a 4-cycle window). When it is 0 the burst length is 4 (a 2-cycle window).
- R8: `rd_intlv` and `wr_intlv` are high during the window cycles of an access whose `cmd_intlv` was 1. Where windows overlap, the values are ORed.
- R9: A read or write with `cmd_ap`=1 accepted in cycle t with latency L (RL for a read, RL-1 for a write) makes `bank_open` for that bank fall in cycle t+L+BL/2.
- R10: `ref_overdue` is high while the cycles since the last accepted refresh (or since reset) exceed `REF_INTERVAL`. It is low in the cycle after a refresh is accepted.
- R11: `cmd_legal` is 0 whenever `cmd_valid` is 0. Opcode 0 (no operation) is legal. Opcode 7 is illegal.
- R12: During and after reset all banks are closed, and the strobes, the burst-type outputs and `ref_overdue` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Opcode: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh, 7 reserved |
| cmd_bank | input | 3 | Target bank |
| cmd_row | input | ROW_W | Row address for activate |
| cmd_ap | input | 1 | Auto-precharge request on read/write |
| cmd_intlv | input | 1 | Burst type: 1 interleaved, 0 sequential |
| cfg_al | input | 3 | Additive latency setting |
| cfg_cl | input | 3 | CAS latency setting |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cmd_legal | output | 1 | Current command is legal |
| sel_row | output | ROW_W | Open row of bank `cmd_bank`, zero if closed |
| bank_open | output | 8 | Per-bank open flag |
| rd_strobe | output | 1 | Read data expected this cycle |
| rd_intlv | output | 1 | Burst type of the read data this cycle |
| wr_strobe | output | 1 | Write data must be driven this cycle |
| wr_intlv | output | 1 | Burst type of the write data this cycle |
| ref_overdue | output | 1 | Refresh interval exceeded |

## Verification
The hardest state to reach is a bank that is still open with an auto-precharge pending. In that state a further read, write or activate to the bank, and any refresh, must be refused. Yet a precharge must still close the bank at once and cancel the countdown. The directed prologue issues a maximum-latency read with auto-precharge and then tries a write and a refresh in the cycles that follow. The random phase mixes auto-precharge on about half of all accesses with frequent precharge-all, so that refreshes and the overdue flag are exercised against banks closing on their own.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;
  localparam int NUM_BANKS = 8;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int MAX_AL    = 6;
  localparam int MIN_CL    = 2;
  localparam int MAX_CL    = 7;
  localparam int MAX_HALF  = 4;
  localparam int LAT_W     = $clog2(MAX_AL + MAX_CL + 1);
  localparam int HALF_W    = $clog2(MAX_HALF + 1);
  localparam int CNT_W     = $clog2(MAX_AL + MAX_CL + MAX_HALF + 1);
  localparam int SCHED_D   = MAX_AL + MAX_CL + MAX_HALF;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6,
    OP_RSV  = 3'd7
  } cmd_op_e;
endpackage

// File: rtl/ddr2_bank_slot.sv
module ddr2_bank_slot #(
  parameter int ROW_W = 14,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             close_i,
  input  logic             ap_load_i,
  input  logic [CNT_W-1:0] ap_len_i,
  output logic             open_o,
  output logic             closing_o,
  output logic [ROW_W-1:0] row_o
);
  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q;
  logic             row_en;

  assign row_en = act_i && !close_i;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    if (close_i) begin
      open_d = 1'b0;
      cnt_d  = '0;
    end else if (act_i) begin
      open_d = 1'b1;
      cnt_d  = '0;
    end else if (ap_load_i) begin
      cnt_d = ap_len_i;
    end else if (cnt_q == CNT_W'(1)) begin
      open_d = 1'b0;
      cnt_d  = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else if (row_en) row_q <= row_i;
  end

  assign open_o    = open_q;
  assign closing_o = (cnt_q != '0);
  assign row_o     = row_q;

  AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> !open_q); // R1
  AST_AP_LOAD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ap_load_i |-> (open_q && cnt_q == '0)); // R2
  AST_CLOSING_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> open_q); // R9
endmodule

// File: rtl/ddr2_phase_sched.sv
module ddr2_phase_sched #(
  parameter int DEPTH  = 17,
  parameter int LAT_W  = 4,
  parameter int HALF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              tag_i,
  output logic              strobe_o,
  output logic              tag_o
);
  logic [DEPTH-1:0] sched_q, sched_d;
  logic [DEPTH-1:0] tag_q, tag_d;
  logic [DEPTH-1:0] mask;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mask[i] = fire_i && ((i + 1) >= int'(lat_i)) &&
                ((i + 1) < int'(lat_i) + int'(half_i));
    end
    sched_d = {1'b0, sched_q[DEPTH-1:1]} | mask;
    tag_d   = {1'b0, tag_q[DEPTH-1:1]} | (tag_i ? mask : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sched_q <= '0;
      tag_q   <= '0;
    end else begin
      sched_q <= sched_d;
      tag_q   <= tag_d;
    end
  end

  assign strobe_o = sched_q[0];
  assign tag_o    = tag_q[0];

  AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> (lat_i != '0)); // R6
  AST_TAG_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    tag_o |-> strobe_o); // R8
endmodule

// File: rtl/ddr2_refresh_watch.sv
module ddr2_refresh_watch #(
  parameter int INTERVAL = 4160,
  parameter int CW       = $clog2(INTERVAL + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ok_i,
  output logic overdue_o
);
  localparam logic [CW-1:0] LIMIT = CW'(INTERVAL);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = ref_ok_i || (cnt_q <= LIMIT);

  always_comb begin
    if (ref_ok_i) cnt_d = '0;
    else          cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign overdue_o = (cnt_q > LIMIT);

  AST_REF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ok_i |=> !overdue_o); // R10
  AST_OVERDUE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (overdue_o && !ref_ok_i) |=> overdue_o); // R10
endmodule

// File: rtl/ddr2_bank_tracker.sv
module ddr2_bank_tracker
  import ddr2_trk_pkg::*;
#(
  parameter int ROW_W        = 14,
  parameter int REF_INTERVAL = 4160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [2:0]       cmd_bank,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic             cmd_ap,
  input  logic             cmd_intlv,
  input  logic [2:0]       cfg_al,
  input  logic [2:0]       cfg_cl,
  input  logic             cfg_bl8,
  output logic             cmd_legal,
  output logic [ROW_W-1:0] sel_row,
  output logic [7:0]       bank_open,
  output logic             rd_strobe,
  output logic             rd_intlv,
  output logic             wr_strobe,
  output logic             wr_intlv,
  output logic             ref_overdue
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  cmd_op_e op;
  assign op = cmd_op_e'(cmd_op);

  logic [LAT_W-1:0]  al_c, cl_c, rd_lat, wr_lat;
  logic [HALF_W-1:0] half;
  logic [CNT_W-1:0]  ap_len;

  always_comb begin
    al_c = (int'(cfg_al) > MAX_AL) ? LAT_W'(MAX_AL) : LAT_W'(cfg_al);
    if (int'(cfg_cl) < MIN_CL)      cl_c = LAT_W'(MIN_CL);
    else if (int'(cfg_cl) > MAX_CL) cl_c = LAT_W'(MAX_CL);
    else                            cl_c = LAT_W'(cfg_cl);
    rd_lat = al_c + cl_c;
    wr_lat = rd_lat - LAT_W'(1);
    half   = cfg_bl8 ? HALF_W'(4) : HALF_W'(2);
    ap_len = ((op == OP_RD) ? CNT_W'(rd_lat) : CNT_W'(wr_lat)) + CNT_W'(half) - CNT_W'(1);
  end

  logic [NUM_BANKS-1:0] open_vec, closing_vec;
  logic [ROW_W-1:0]     row_vec [NUM_BANKS];
  logic                 sel_open, sel_busy;

  assign sel_open = open_vec[cmd_bank];
  assign sel_busy = closing_vec[cmd_bank];

  always_comb begin
    cmd_legal = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_NOP:          cmd_legal = 1'b1;
        OP_ACT:          cmd_legal = !sel_open;
        OP_RD, OP_WR:    cmd_legal = sel_open && !sel_busy;
        OP_PRE, OP_PREA: cmd_legal = 1'b1;
        OP_REF:          cmd_legal = (open_vec == '0);
        default:         cmd_legal = 1'b0;
      endcase
    end
  end

  logic accept, rd_fire, wr_fire, ref_fire;
  assign accept   = cmd_valid && cmd_legal;
  assign rd_fire  = accept && (op == OP_RD);
  assign wr_fire  = accept && (op == OP_WR);
  assign ref_fire = accept && (op == OP_REF);

  logic [NUM_BANKS-1:0] act_vec, close_vec, ap_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_vec[b]   = accept && (op == OP_ACT) && (cmd_bank == BANK_W'(b));
    assign close_vec[b] = accept && ((op == OP_PREA) ||
                          ((op == OP_PRE) && (cmd_bank == BANK_W'(b))));
    assign ap_vec[b]    = (rd_fire || wr_fire) && cmd_ap && (cmd_bank == BANK_W'(b));

    ddr2_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .act_i     (act_vec[b]),
      .row_i     (cmd_row),
      .close_i   (close_vec[b]),
      .ap_load_i (ap_vec[b]),
      .ap_len_i  (ap_len),
      .open_o    (open_vec[b]),
      .closing_o (closing_vec[b]),
      .row_o     (row_vec[b])
    );
  end

  assign sel_row   = sel_open ? row_vec[cmd_bank] : '0;
  assign bank_open = open_vec;

  ddr2_phase_sched #(.DEPTH(SCHED_D), .LAT_W(LAT_W), .HALF_W(HALF_W)) u_rd_sched (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .fire_i   (rd_fire),
    .lat_i    (rd_lat),
    .half_i   (half),
    .tag_i    (cmd_intlv),
    .strobe_o (rd_strobe),
    .tag_o    (rd_intlv)
  );

  ddr2_phase_sched #(.DEPTH(SCHED_D), .LAT_W(LAT_W), .HALF_W(HALF_W)) u_wr_sched (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .fire_i   (wr_fire),
    .lat_i    (wr_lat),
    .half_i   (half),
    .tag_i    (cmd_intlv),
    .strobe_o (wr_strobe),
    .tag_o    (wr_intlv)
  );

  ddr2_refresh_watch #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .ref_ok_i  (ref_fire),
    .overdue_o (ref_overdue)
  );

  AST_IDLE_NOT_LEGAL: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cmd_valid |-> !cmd_legal); // R11
  AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!core_rst_n)
    ref_fire |-> (bank_open == '0)); // R4
  AST_PREA_CLEARS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (accept && op == OP_PREA) |=> (bank_open == '0)); // R3
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (accept && op == OP_ACT) |=> bank_open[$past(cmd_bank)]); // R1
endmodule

// File: tb/sim_ddr2_bank_tracker.sv
module sim_ddr2_bank_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W      = 14;
  localparam int REF_I      = 150;

  logic             clk, rst_n;
  logic             cmd_valid, cmd_ap, cmd_intlv, cfg_bl8;
  logic [2:0]       cmd_op, cmd_bank, cfg_al, cfg_cl;
  logic [ROW_W-1:0] cmd_row, sel_row;
  logic             cmd_legal, rd_strobe, rd_intlv, wr_strobe, wr_intlv, ref_overdue;
  logic [7:0]       bank_open;

  ddr2_bank_tracker #(.ROW_W(ROW_W), .REF_INTERVAL(REF_I)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_ap(cmd_ap), .cmd_intlv(cmd_intlv),
    .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8), .cmd_legal(cmd_legal),
    .sel_row(sel_row), .bank_open(bank_open), .rd_strobe(rd_strobe), .rd_intlv(rd_intlv),
    .wr_strobe(wr_strobe), .wr_intlv(wr_intlv), .ref_overdue(ref_overdue)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int cyc     = 0;

  bit             m_open [8];
  int             m_close_at [8];
  logic [ROW_W-1:0] m_row [8];
  bit             rq [64], rt [64], wq [64], wt [64];
  int             m_ref;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int clamp_al(input int a);
    return (a > 6) ? 6 : a;
  endfunction

  function automatic int clamp_cl(input int c);
    return (c < 2) ? 2 : ((c > 7) ? 7 : c);
  endfunction

  function automatic bit exp_legal(input bit v, input int op, input int b);
    bit all_closed;
    all_closed = 1;
    for (int i = 0; i < 8; i++) if (m_open[i]) all_closed = 0;
    if (!v) return 0;
    case (op)
      0: return 1;
      1: return !m_open[b];
      2, 3: return m_open[b] && (m_close_at[b] < 0);
      4, 5: return 1;
      6: return all_closed;
      default: return 0;
    endcase
  endfunction

  function automatic string legal_tag(input bit v, input int op);
    if (!v) return "R11";
    case (op)
      1: return "R1";
      2, 3: return "R2";
      4, 5: return "R3";
      6: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic do_cycle(input bit v, input int op, input int b, input int row,
                          input bit ap, input bit il, input int al, input int cl, input bit bl8);
    bit   lg;
    int   rl, h, lat, exp_open;
    logic [ROW_W-1:0] exp_row;
    @(negedge clk);
    for (int i = 0; i < 8; i++)
      if (m_close_at[i] == cyc) begin m_open[i] = 0; m_close_at[i] = -1; end
    cmd_valid = v; cmd_op = 3'(op); cmd_bank = 3'(b); cmd_row = ROW_W'(row);
    cmd_ap = ap; cmd_intlv = il; cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = bl8;
    #1;
    lg = exp_legal(v, op, b);
    chk(legal_tag(v, op), "cmd_legal", int'(cmd_legal), int'(lg));
    exp_row = m_open[b] ? m_row[b] : '0;
    chk("R1", "sel_row", int'(sel_row), int'(exp_row));
    exp_open = 0;
    for (int i = 0; i < 8; i++) exp_open |= (int'(m_open[i]) << i);
    chk("R9", "bank_open", int'(bank_open), exp_open);
    chk("R5 R7", "rd_strobe", int'(rd_strobe), int'(rq[cyc%64]));
    chk("R8", "rd_intlv", int'(rd_intlv), int'(rt[cyc%64]));
    chk("R6 R7", "wr_strobe", int'(wr_strobe), int'(wq[cyc%64]));
    chk("R8", "wr_intlv", int'(wr_intlv), int'(wt[cyc%64]));
    chk("R10", "ref_overdue", int'(ref_overdue), int'(m_ref > REF_I));
    rq[cyc%64] = 0; rt[cyc%64] = 0; wq[cyc%64] = 0; wt[cyc%64] = 0;
    rl = clamp_al(al) + clamp_cl(cl);
    h  = bl8 ? 4 : 2;
    if (lg) begin
      case (op)
        1: begin m_open[b] = 1; m_row[b] = ROW_W'(row); m_close_at[b] = -1; end
        2, 3: begin
          lat = (op == 2) ? rl : rl - 1;
          for (int k = 0; k < h; k++) begin
            if (op == 2) begin rq[(cyc+lat+k)%64] = 1; if (il) rt[(cyc+lat+k)%64] = 1; end
            else         begin wq[(cyc+lat+k)%64] = 1; if (il) wt[(cyc+lat+k)%64] = 1; end
          end
          if (ap) m_close_at[b] = cyc + lat + h;
        end
        4: begin m_open[b] = 0; m_close_at[b] = -1; end
        5: for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_close_at[i] = -1; end
        default: ;
      endcase
    end
    if (lg && op == 6) m_ref = 0;
    else if (m_ref <= REF_I) m_ref++;
    @(posedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_cycle(0, 0, 0, 0, 0, 0, 0, 2, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_d2a2));
    for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_close_at[i] = -1; m_row[i] = '0; end
    for (int i = 0; i < 64; i++) begin rq[i] = 0; rt[i] = 0; wq[i] = 0; wt[i] = 0; end
    m_ref = 0;
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_bank = 0; cmd_row = 0;
    cmd_ap = 0; cmd_intlv = 0; cfg_al = 0; cfg_cl = 2; cfg_bl8 = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12", "bank_open in reset", int'(bank_open), 0);
      chk("R12", "strobes in reset", int'({rd_strobe, wr_strobe, rd_intlv, wr_intlv}), 0);
      chk("R12", "ref_overdue in reset", int'(ref_overdue), 0);
    end
    rst_n = 1;
    repeat (3) @(posedge clk);

    // directed corners
    do_cycle(1, 6, 0, 0, 0, 0, 0, 2, 0);            // R4 refresh with all closed
    do_cycle(1, 4, 3, 0, 0, 0, 0, 2, 0);            // R3 precharge closed bank
    do_cycle(1, 2, 2, 0, 0, 0, 0, 2, 0);            // R2 read to closed bank
    do_cycle(1, 1, 2, 'h1234, 0, 0, 0, 2, 0);       // R1 activate
    do_cycle(1, 1, 2, 'h0055, 0, 0, 0, 2, 0);       // R1 activate open bank
    do_cycle(1, 6, 0, 0, 0, 0, 0, 2, 0);            // R4 refresh with open bank
    do_cycle(1, 2, 2, 0, 1, 1, 6, 7, 1);            // R5 R7 R8 R9 max latency, ap
    do_cycle(1, 3, 2, 0, 0, 0, 0, 2, 0);            // R2 write to closing bank
    do_cycle(1, 6, 0, 0, 0, 0, 0, 2, 0);            // R4 refresh while closing
    do_cycle(1, 1, 5, 'h3fff, 0, 0, 0, 2, 0);
    do_cycle(1, 3, 5, 0, 0, 0, 0, 2, 0);            // R6 minimum write latency
    do_cycle(1, 7, 5, 0, 0, 0, 0, 2, 0);            // R11 reserved opcode
    idle(20);
    do_cycle(1, 1, 1, 'h0abc, 0, 0, 0, 2, 0);
    do_cycle(1, 2, 1, 0, 1, 0, 7, 0, 0);            // R5 clamps, R9 ap
    do_cycle(1, 4, 1, 0, 0, 0, 0, 2, 0);            // R3 precharge cancels ap
    idle(12);
    do_cycle(1, 1, 4, 'h0111, 0, 0, 0, 2, 0);
    do_cycle(1, 1, 6, 'h0222, 0, 0, 0, 2, 0);
    do_cycle(1, 5, 0, 0, 0, 0, 0, 2, 0);            // R3 precharge-all
    do_cycle(1, 6, 0, 0, 0, 0, 0, 2, 0);            // R4 R10 refresh
    idle(REF_I + 5);                                // R10 overdue rises
    do_cycle(1, 6, 0, 0, 0, 0, 0, 2, 0);            // R10 clear
    idle(3);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r, op;
      r = int'($urandom % 16);
      if (r < 4)       op = 1;
      else if (r < 7)  op = 2;
      else if (r < 10) op = 3;
      else if (r < 12) op = 4;
      else if (r < 13) op = 5;
      else if (r < 14) op = 6;
      else if (r < 15) op = 0;
      else             op = 7;
      do_cycle(($urandom % 8) != 0, op, int'($urandom % 8), int'($urandom % 16384),
               $urandom % 2, $urandom % 2, int'($urandom % 8), int'($urandom % 8),
               $urandom % 2);
    end
    idle(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule